// File: doc/BRIEF.md
# IDE PIO Register Write Sequencer

This block performs a single host-side register write on a parallel IDE bus in programmed-I/O mode. A requester presents a write request with a register address, a data word and a PIO timing mode from 0 to 4. The block accepts the request through a ready/request handshake and captures the mode at that moment. It then runs a fixed sequence of timed phases: a configuration setup wait, a data-drive phase with the strobe idle, a phase with the write strobe asserted, and a recovery phase. When recovery ends it returns to ready and emits a one-cycle completion pulse.

All delays are given in nanoseconds per mode and are turned into cycle counts at elaboration. Each count is the delay divided by the clock period (10 ns by default) and rounded up. If the three bus phases together are shorter than the mode's minimum cycle time, the recovery phase is lengthened by the shortfall. Mode codes 5, 6 and 7 select the mode 0 timing.

Top module: `pio_write_seq`

## Requirements
- R1: After synchronous reset, `ready` is 1, `done` is 0, `bus_oe` is 0 and `wr_strobe` is 0 (its idle level).
- R2: A request is accepted on a clock edge where `req` and `ready` are both 1. From the next cycle, `ready` stays 0 until the cycle in which `done` is 1.
- R3: The mode is sampled only at acceptance. Changing `req_mode` later has no effect on the running write. Codes 5 to 7 give exactly the mode 0 timing.
- R4: After acceptance the block waits a setup time of 3, 2, 2, 1, 1 cycles (modes 0..4) with `bus_oe` 0 and `wr_strobe` 0.
- R5: The data phase follows: `bus_oe` is 1 and `wr_strobe` is 0 for 7, 5, 3, 3, 3 cycles.
- R6: The strobe phase follows: `wr_strobe` is 1 and `bus_oe` is 1 for 29, 29, 29, 8, 7 cycles.
- R7: The recovery phase follows: `bus_oe` is 0, `wr_strobe` is 0 and `ready` is 0 for max(P3, MIN − P1 − P2) cycles. P3 is 24, 5, 2, 7, 3 cycles and MIN is 60, 39, 33, 18, 12 cycles.
- R8: The data, strobe and recovery phases together last at least MIN cycles. Total busy time is therefore 63, 41, 36, 19 and 14 cycles for modes 0..4.
- R9: `done` is high for exactly one cycle. That cycle is the first one in which `ready` is back at 1.
- R10: `wr_addr` and `wr_data` equal the accepted address and data and do not change while `bus_oe` is 1. They keep these values until the next acceptance.
- R11: A `req` raised while `ready` is 0 is ignored. It changes neither the timing nor the `wr_addr`/`wr_data` outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Write request |
| req_mode | input | MODE_W | PIO timing mode, sampled at acceptance |
| req_addr | input | ADDR_W | Register address to write |
| req_data | input | DATA_W | Data word to write |
| ready | output | 1 | Block idle and able to accept a request |
| done | output | 1 | One-cycle pulse at the end of a write |
| wr_addr | output | ADDR_W | Held register address for the bus |
| wr_data | output | DATA_W | Held data word for the bus |
| bus_oe | output | 1 | Data bus drive enable |
| wr_strobe | output | 1 | Write strobe, active high, idle low |

## Verification
Acceptance happens on an edge. From that edge, the phase outputs for cycle n after acceptance come from the n-th entry of a schedule built in the bench from the nanosecond tables and the rounding and padding rules. `done` is due on the edge after the last recovery cycle, which is busy time plus one edge from acceptance. The reference model advances on every rising edge using only the inputs. The DUT outputs are compared against it at the following falling edge, so every output is checked in the exact cycle it is due. Per-mode busy lengths are also measured in whole cycles and checked against the stated totals.

// File: rtl/pio_wr_pkg.sv
package pio_wr_pkg;

    localparam int CNT_W     = 8;
    localparam int NUM_MODES = 5;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_DRIVE,
        PH_STROBE,
        PH_RECOVER
    } phase_e;

    typedef struct packed {
        cnt_t setup;
        cnt_t drive;
        cnt_t strobe;
        cnt_t recover;
    } timing_t;

    function automatic int ns_to_cycles(int ns, int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int cfg_setup_ns(int m);
        case (m)
            1: return 20;
            2: return 15;
            3: return 10;
            4: return 5;
            default: return 30;
        endcase
    endfunction

    function automatic int drive_ns(int m);
        case (m)
            1: return 50;
            2: return 30;
            3: return 30;
            4: return 25;
            default: return 70;
        endcase
    endfunction

    function automatic int strobe_ns(int m);
        case (m)
            3: return 80;
            4: return 70;
            default: return 290;
        endcase
    endfunction

    function automatic int recover_ns(int m);
        case (m)
            1: return 50;
            2: return 20;
            3: return 70;
            4: return 25;
            default: return 240;
        endcase
    endfunction

    function automatic int min_cycle_ns(int m);
        case (m)
            1: return 383;
            2: return 330;
            3: return 180;
            4: return 120;
            default: return 600;
        endcase
    endfunction

    function automatic timing_t mode_timing(int m, int clk_ns);
        timing_t t;
        int s, p1, p2, p3, mn, pad;
        s   = ns_to_cycles(cfg_setup_ns(m), clk_ns);
        p1  = ns_to_cycles(drive_ns(m), clk_ns);
        p2  = ns_to_cycles(strobe_ns(m), clk_ns);
        p3  = ns_to_cycles(recover_ns(m), clk_ns);
        mn  = ns_to_cycles(min_cycle_ns(m), clk_ns);
        pad = (mn > p1 + p2 + p3) ? (mn - p1 - p2 - p3) : 0;
        t.setup   = cnt_t'(s);
        t.drive   = cnt_t'(p1);
        t.strobe  = cnt_t'(p2);
        t.recover = cnt_t'(p3 + pad);
        return t;
    endfunction

endpackage

// File: rtl/pio_mode_timing.sv
module pio_mode_timing
    import pio_wr_pkg::*;
#(
    parameter int MODE_W = 3,
    parameter int CLK_NS = 10
) (
    input  logic [MODE_W-1:0] mode,
    output timing_t           timing
);
    localparam int LUT_DEPTH = 2 ** MODE_W;

    timing_t lut [LUT_DEPTH];

    for (genvar m = 0; m < LUT_DEPTH; m++) begin : g_mode
        localparam int EFF = (m < NUM_MODES) ? m : 0;
        assign lut[m] = mode_timing(EFF, CLK_NS);
    end

    assign timing = lut[mode];

endmodule

// File: rtl/pio_phase_fsm.sv
module pio_phase_fsm
    import pio_wr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    req,
    input  timing_t timing_in,
    output phase_e  phase,
    output logic    accept,
    output logic    done
);
    typedef struct packed {
        phase_e  ph;
        cnt_t    cnt;
        timing_t tim;
        logic    done;
    } fsm_t;

    fsm_t st_d, st_q;
    logic expired;

    assign expired = (st_q.cnt == '0);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        accept    = 1'b0;
        case (st_q.ph)
            PH_IDLE: begin
                if (req) begin
                    accept   = 1'b1;
                    st_d.ph  = PH_SETUP;
                    st_d.tim = timing_in;
                    st_d.cnt = timing_in.setup - cnt_t'(1);
                end
            end
            PH_SETUP: begin
                if (expired) begin
                    st_d.ph  = PH_DRIVE;
                    st_d.cnt = st_q.tim.drive - cnt_t'(1);
                end else begin
                    st_d.cnt = st_q.cnt - cnt_t'(1);
                end
            end
            PH_DRIVE: begin
                if (expired) begin
                    st_d.ph  = PH_STROBE;
                    st_d.cnt = st_q.tim.strobe - cnt_t'(1);
                end else begin
                    st_d.cnt = st_q.cnt - cnt_t'(1);
                end
            end
            PH_STROBE: begin
                if (expired) begin
                    st_d.ph  = PH_RECOVER;
                    st_d.cnt = st_q.tim.recover - cnt_t'(1);
                end else begin
                    st_d.cnt = st_q.cnt - cnt_t'(1);
                end
            end
            PH_RECOVER: begin
                if (expired) begin
                    st_d.ph   = PH_IDLE;
                    st_d.done = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - cnt_t'(1);
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ph   <= PH_IDLE;
            st_q.cnt  <= '0;
            st_q.tim  <= '0;
            st_q.done <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.ph;
    assign done  = st_q.done;

endmodule

// File: rtl/pio_bus_hold.sv
module pio_bus_hold #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [DATA_W-1:0] data_out
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (capture) begin
            hold_d.addr = addr_in;
            hold_d.data = data_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign addr_out = hold_q.addr;
    assign data_out = hold_q.data;

endmodule

// File: rtl/pio_write_seq.sv
module pio_write_seq
    import pio_wr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int MODE_W = 3,
    parameter int CLK_NS = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [MODE_W-1:0] req_mode,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              ready,
    output logic              done,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              bus_oe,
    output logic              wr_strobe
);
    timing_t sel_timing;
    phase_e  phase;
    logic    accept;

    pio_mode_timing #(
        .MODE_W (MODE_W),
        .CLK_NS (CLK_NS)
    ) u_timing (
        .mode   (req_mode),
        .timing (sel_timing)
    );

    pio_phase_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .timing_in (sel_timing),
        .phase     (phase),
        .accept    (accept),
        .done      (done)
    );

    pio_bus_hold #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_hold (
        .clk      (clk),
        .rst      (rst),
        .capture  (accept),
        .addr_in  (req_addr),
        .data_in  (req_data),
        .addr_out (wr_addr),
        .data_out (wr_data)
    );

    assign ready     = (phase == PH_IDLE);
    assign bus_oe    = (phase == PH_DRIVE) || (phase == PH_STROBE);
    assign wr_strobe = (phase == PH_STROBE);

endmodule

// File: rtl/pio_write_seq_chk.sv
module pio_write_seq_chk
    import pio_wr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int CLK_NS = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              ready,
    input logic              done,
    input logic              bus_oe,
    input logic              wr_strobe,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data
);
    localparam int STROBE_MIN = ns_to_cycles(70, CLK_NS);

    logic [15:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst || !wr_strobe) begin
            hi_cnt <= '0;
        end else if (hi_cnt != 16'hFFFF) begin
            hi_cnt <= hi_cnt + 16'd1;
        end
    end

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ready && !bus_oe && !wr_strobe && !done)); // R1

    AST_DRIVE_BEFORE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_strobe) |-> $past(bus_oe)); // R5

    AST_STROBE_INSIDE_DRIVE: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> (bus_oe && !ready)); // R6

    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_strobe) |-> (hi_cnt >= 16'(STROBE_MIN))); // R6

    AST_RECOVERY_BUSY: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_strobe) |-> (!ready && !bus_oe)); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_DONE_WITH_READY: assert property (@(posedge clk) disable iff (rst)
        done |-> ready); // R9

    AST_HOLD_BUS: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && $past(bus_oe)) |-> ($stable(wr_addr) && $stable(wr_data))); // R10

endmodule

bind pio_write_seq pio_write_seq_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CLK_NS (CLK_NS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ready     (ready),
    .done      (done),
    .bus_oe    (bus_oe),
    .wr_strobe (wr_strobe),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
);

// File: tb/pio_write_seq_tb_top.sv
module pio_write_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 16;
    localparam int MODE_W     = 3;
    localparam int WD_LIMIT   = 100000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req = 1'b0;
    logic [MODE_W-1:0] req_mode = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic              ready, done, bus_oe, wr_strobe;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    int checks   = 0;
    int failures = 0;
    int wd       = 0;

    // requirement tables in ns, modes 0..4
    int t_setup [5] = '{30, 20, 15, 10, 5};
    int t_drive [5] = '{70, 50, 30, 30, 25};
    int t_strobe[5] = '{290, 290, 290, 80, 70};
    int t_recov [5] = '{240, 50, 20, 70, 25};
    int t_min   [5] = '{600, 383, 330, 180, 120};
    int t_total [5] = '{63, 41, 36, 19, 14};

    always #(CLK_PERIOD/2) clk = ~clk;

    pio_write_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .MODE_W (MODE_W),
        .CLK_NS (CLK_PERIOD)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .req_mode  (req_mode),
        .req_addr  (req_addr),
        .req_data  (req_data),
        .ready     (ready),
        .done      (done),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .bus_oe    (bus_oe),
        .wr_strobe (wr_strobe)
    );

    function automatic int cyc(int ns);
        return (ns + CLK_PERIOD - 1) / CLK_PERIOD;
    endfunction

    function automatic void check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endfunction

    // reference model: phase schedule queue (1 setup, 2 drive, 3 strobe, 4 recover)
    int q[$];
    int cur      = 0;
    bit exp_done = 1'b0;
    int exp_addr = 0;
    int exp_data = 0;
    bit model_on = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            cur      = 0;
            exp_done = 1'b0;
            exp_addr = 0;
            exp_data = 0;
        end else begin
            exp_done = 1'b0;
            if (q.size() > 0) begin
                cur = q.pop_front();
            end else if (cur != 0) begin
                cur      = 0;
                exp_done = 1'b1;
            end else if (req) begin
                int m, s, p1, p2, p3, r;
                m  = (int'(req_mode) < 5) ? int'(req_mode) : 0;
                s  = cyc(t_setup[m]);
                p1 = cyc(t_drive[m]);
                p2 = cyc(t_strobe[m]);
                p3 = cyc(t_recov[m]);
                r  = (cyc(t_min[m]) - p1 - p2 > p3) ? cyc(t_min[m]) - p1 - p2 : p3;
                for (int i = 0; i < s;  i++) q.push_back(1);
                for (int i = 0; i < p1; i++) q.push_back(2);
                for (int i = 0; i < p2; i++) q.push_back(3);
                for (int i = 0; i < r;  i++) q.push_back(4);
                exp_addr = int'(req_addr);
                exp_data = int'(req_data);
                cur = q.pop_front();
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (model_on && !rst) begin
            string ptag;
            case (cur)
                1: ptag = "R4";
                2: ptag = "R5";
                3: ptag = "R6";
                4: ptag = "R7";
                default: ptag = "R2";
            endcase
            check(ready == (cur == 0), "R2 ready", int'(ready), int'(cur == 0));
            check(bus_oe == (cur == 2 || cur == 3), ptag, int'(bus_oe), int'(cur == 2 || cur == 3));
            check(wr_strobe == (cur == 3), ptag, int'(wr_strobe), int'(cur == 3));
            check(done == exp_done, "R9 done", int'(done), int'(exp_done));
            if (cur == 2 || cur == 3) begin
                check(int'(wr_addr) == exp_addr, "R10 addr", int'(wr_addr), exp_addr);
                check(int'(wr_data) == exp_data, "R10 data", int'(wr_data), exp_data);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        wd++;
        if (wd > WD_LIMIT) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected<%0d", wd, WD_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic do_write(input int mode, input int addr, input int data,
                            input int mode_after, output int busy);
        @(negedge clk);
        req      = 1'b1;
        req_mode = MODE_W'(mode);
        req_addr = ADDR_W'(addr);
        req_data = DATA_W'(data);
        @(negedge clk);
        req      = 1'b0;
        req_mode = MODE_W'(mode_after);
        busy = 0;
        while (!done) begin
            busy++;
            @(negedge clk);
        end
    endtask

    initial begin
        int busy;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_on = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(ready === 1'b1, "R1 ready", int'(ready), 1);
        check(done === 1'b0, "R1 done", int'(done), 0);
        check(bus_oe === 1'b0, "R1 oe", int'(bus_oe), 0);
        check(wr_strobe === 1'b0, "R1 strobe", int'(wr_strobe), 0);

        // R8: busy length per mode; mode changed after acceptance (R3)
        for (int m = 0; m < 5; m++) begin
            do_write(m, m + 3, 16'h1000 + m * 16'h0111, 4 - m, busy);
            check(busy == t_total[m], "R8 total busy", busy, t_total[m]);
            check(busy - cyc(t_setup[m]) >= cyc(t_min[m]), "R8 min cycle",
                  busy - cyc(t_setup[m]), cyc(t_min[m]));
        end

        // R3: codes 5..7 behave as mode 0
        for (int m = 5; m < 8; m++) begin
            do_write(m, 9, 16'hA5A5 ^ m, 4, busy);
            check(busy == t_total[0], "R3 high code", busy, t_total[0]);
        end

        // R11: request during busy ignored
        @(negedge clk);
        req = 1'b1; req_mode = 3'd3; req_addr = 4'h7; req_data = 16'hBEEF;
        @(negedge clk);
        req = 1'b0; busy = 0;
        repeat (5) @(negedge clk);
        req = 1'b1; req_mode = 3'd0; req_addr = 4'h2; req_data = 16'h1234;
        @(negedge clk);
        req = 1'b0;
        busy = 6;
        while (!done) begin
            busy++;
            @(negedge clk);
        end
        check(busy == t_total[3], "R11 timing", busy, t_total[3]);
        check(wr_data == 16'hBEEF, "R11 data", int'(wr_data), 16'hBEEF);
        check(wr_addr == 4'h7, "R11 addr", int'(wr_addr), 7);

        // R2: back-to-back with req held high, accepted in the done cycle
        req = 1'b1; req_mode = 3'd4; req_addr = 4'hC; req_data = 16'h5A5A;
        repeat (40) @(negedge clk);
        req = 1'b0;
        repeat (20) @(negedge clk);
        check(ready == 1'b1, "R2 idle after burst", int'(ready), 1);
        check(wr_data == 16'h5A5A, "R10 final hold", int'(wr_data), 16'h5A5A);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule